// File: doc/BRIEF.md
# Multi-Row Write-Coalescing Buffer Controller

This block sits in front of a slow, wear-limited non-volatile memory array. It serves word reads and writes from a host port out of a small set of narrow row buffers. A request whose row is held in any buffer completes in one cycle and does not touch the array. Host writes land in the buffered copy and are merged there. The array sees a write only when a modified row is pushed out.

On a miss, the controller first picks a victim buffer. An empty buffer is taken before any occupied one. When all buffers are occupied, the one touched longest ago is taken. If the victim holds modified data, only the words flagged as modified are written back, one array operation each; a clean victim is dropped without any array write. The requested row is then read into the buffer word by word, and the stalled request completes. Every array operation waits out its full latency: `RD_LAT` cycles for a read and `WR_LAT` cycles for a write. A running count of array word writes is exported so that the wear saving can be measured.

The array is modelled inside the block by a latency-accurate store with a request/ready handshake. Reset clears that store to zero.

Top module: `rowbuf_ctrl`

## Requirements
- R1: A host request whose row is held in a valid buffer raises `host_ready` in the cycle after the clock edge that first sees `host_req`. A read returns the most recently written value of that word.
- R2: Any number of host writes to buffered rows leave `wr_count` unchanged.
- R3: Evicting a modified row writes exactly its modified words to the array, so `wr_count` rises by that number. Data written earlier can be read back after the row has been evicted and refetched.
- R4: Evicting a row with no modified words performs no array write.
- R5: A miss completes 2 + k·(WR_LAT+2) + W·(RD_LAT+2) edges after the request is seen, where k is the number of modified words in the victim and W is the number of words per row. The array never receives a new operation while one is in flight.
- R6: `host_ready` stays low for the whole writeback and fill of a miss.
- R7: Empty buffers are filled before any occupied one is evicted. Among occupied buffers, the least recently served one is evicted.
- R8: A row fill clears every modified flag of its buffer. A refetched row that is not written again is later evicted with no array write.
- R9: After reset, `host_ready` is low, `wr_count` is zero, and every array word reads as zero.
- R10: `host_addr` splits into a row number in its upper `ROW_W` bits and a word index in its lower log2(`WORDS`) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request held high until `host_ready` is seen |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+log2(WORDS) | {row, word index} |
| host_wdata | input | WORD_W | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | WORD_W | Read data, valid with `host_ready` |
| wr_count | output | CNT_W | Running count of array word writes |

## Verification
The main function is exercised with four patterns:
- Repeated writes to the same and to different words of a buffered row. These separate coalescing from write-through.
- A run of misses onto empty buffers. This separates invalid-first placement from premature eviction, because an eviction would show up as extra latency.
- Misses whose victims have zero, one, two or all eight modified words. The exact stall length and the write count tell partial writeback apart from a full-row or skipped writeback.
- Refetched rows that are evicted again without writes. These show whether the fill really cleared the modified flags.

Read-back after refetch, and after a second reset, confirms that the data went to and came from the array.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_ISSUE,
    ST_WB_WAIT,
    ST_FILL_ISSUE,
    ST_FILL_WAIT
  } rb_state_t;

  // Cycles a miss takes, from the edge that sees the request to the edge that answers it.
  function automatic int miss_edges(input int dirty_words, input int words,
                                    input int rd_lat, input int wr_lat);
    return 2 + dirty_words * (wr_lat + 2) + words * (rd_lat + 2);
  endfunction

endpackage

// File: rtl/rowbuf_nvarray.sv
module rowbuf_nvarray #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int WORD_W = 32,
  parameter int RD_LAT = 5,
  parameter int WR_LAT = 15,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [WORD_W-1:0] wdata,
  output logic              busy,
  output logic              ready,
  output logic [WORD_W-1:0] rdata,
  output logic [CNT_W-1:0]  wr_count
);
  localparam int AW      = ROW_W + COL_W;
  localparam int DEPTH   = 1 << AW;
  localparam int MAX_LAT = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [LAT_W-1:0]  cnt;
  logic              op_we;
  logic [AW-1:0]     op_addr;
  logic [WORD_W-1:0] op_data;
  logic              accept;

  assign accept = req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      busy     <= 1'b0;
      ready    <= 1'b0;
      cnt      <= '0;
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      rdata    <= '0;
      wr_count <= '0;
    end else begin
      ready <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= we ? LAT_W'(WR_LAT) : LAT_W'(RD_LAT);
        op_we   <= we;
        op_addr <= {row, col};
        op_data <= wdata;
        if (we) wr_count <= wr_count + 1'b1;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == LAT_W'(1)) begin
          busy  <= 1'b0;
          ready <= 1'b1;
          if (op_we) mem[op_addr] <= op_data;
          else       rdata        <= mem[op_addr];
        end
      end
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !busy); // R5
  AST_WRITE_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && we) |=> (wr_count == $past(wr_count) + 1'b1)); // R3
  AST_READ_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(accept && we)) |=> $stable(wr_count)); // R2

endmodule

// File: rtl/rowbuf_lru.sv
module rowbuf_lru #(
  parameter int NUM_BUFS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch,
  input  logic [$clog2(NUM_BUFS)-1:0] touch_idx,
  output logic [$clog2(NUM_BUFS)-1:0] oldest_idx
);
  localparam int IDX_W = $clog2(NUM_BUFS);

  logic [IDX_W-1:0]    age [NUM_BUFS];
  logic [NUM_BUFS-1:0] oldest_vec;

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_old
    assign oldest_vec[g] = (age[g] == IDX_W'(NUM_BUFS - 1));
  end

  function automatic logic [IDX_W-1:0] vec_to_idx(input logic [NUM_BUFS-1:0] v);
    vec_to_idx = '0;
    for (int k = 0; k < NUM_BUFS; k++) if (v[k]) vec_to_idx = IDX_W'(k);
  endfunction

  assign oldest_idx = vec_to_idx(oldest_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_BUFS; k++) age[k] <= IDX_W'(k);
    end else if (touch) begin
      for (int k = 0; k < NUM_BUFS; k++) begin
        if (IDX_W'(k) == touch_idx)     age[k] <= '0;
        else if (age[k] < age[touch_idx]) age[k] <= age[k] + 1'b1;
      end
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1); // R7
  AST_TOUCH_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (age[$past(touch_idx)] == '0)); // R7

endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl #(
  parameter int NUM_BUFS = 4,
  parameter int WORDS    = 8,
  parameter int WORD_W   = 32,
  parameter int ROW_W    = 4,
  parameter int RD_LAT   = 5,
  parameter int WR_LAT   = 15,
  parameter int CNT_W    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               host_req,
  input  logic                               host_we,
  input  logic [ROW_W+$clog2(WORDS)-1:0]     host_addr,
  input  logic [WORD_W-1:0]                  host_wdata,
  output logic                               host_ready,
  output logic [WORD_W-1:0]                  host_rdata,
  output logic [CNT_W-1:0]                   wr_count
);
  import rowbuf_pkg::*;

  localparam int COL_W = $clog2(WORDS);
  localparam int BUF_W = $clog2(NUM_BUFS);

  // buffer state
  logic [WORD_W-1:0]   buf_data  [NUM_BUFS][WORDS];
  logic [ROW_W-1:0]    buf_tag   [NUM_BUFS];
  logic [WORDS-1:0]    buf_dirty [NUM_BUFS];
  logic [NUM_BUFS-1:0] buf_valid;

  // control state
  rb_state_t        state;
  logic [BUF_W-1:0] vic;
  logic [COL_W-1:0] col_cnt;
  logic [ROW_W-1:0] row_latch;

  // request decode (R10)
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  assign req_row = host_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = host_addr[COL_W-1:0];

  // hit detection
  logic [NUM_BUFS-1:0] hit_vec;
  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_hit
    assign hit_vec[g] = buf_valid[g] && (buf_tag[g] == req_row);
  end

  function automatic logic [BUF_W-1:0] buf_index(input logic [NUM_BUFS-1:0] v);
    buf_index = '0;
    for (int k = NUM_BUFS - 1; k >= 0; k--) if (v[k]) buf_index = BUF_W'(k);
  endfunction

  function automatic logic [COL_W-1:0] first_dirty(input logic [WORDS-1:0] v);
    first_dirty = '0;
    for (int k = WORDS - 1; k >= 0; k--) if (v[k]) first_dirty = COL_W'(k);
  endfunction

  logic [BUF_W-1:0] hit_idx, lru_idx, victim;
  assign hit_idx = buf_index(hit_vec);
  assign victim  = (&buf_valid) ? lru_idx : buf_index(~buf_valid);

  // named events
  logic serve_hit, start_miss, wb_issue, fill_issue, wb_done_word;
  logic fill_word_done, fill_done, victim_dirty;
  logic [COL_W-1:0] wb_col;

  assign serve_hit      = (state == ST_IDLE) && host_req && !host_ready && (|hit_vec);
  assign start_miss     = (state == ST_IDLE) && host_req && !host_ready && !(|hit_vec);
  assign victim_dirty   = buf_valid[victim] && (|buf_dirty[victim]);
  assign wb_issue       = (state == ST_WB_ISSUE);
  assign fill_issue     = (state == ST_FILL_ISSUE);
  assign wb_col         = first_dirty(buf_dirty[vic]);

  // array port
  logic              arr_req, arr_we, arr_busy, arr_ready;
  logic [ROW_W-1:0]  arr_row;
  logic [COL_W-1:0]  arr_col;
  logic [WORD_W-1:0] arr_wdata, arr_rdata;

  assign wb_done_word   = (state == ST_WB_WAIT) && arr_ready;
  assign fill_word_done = (state == ST_FILL_WAIT) && arr_ready;
  assign fill_done      = fill_word_done && (col_cnt == COL_W'(WORDS - 1));

  assign arr_req   = wb_issue || fill_issue;
  assign arr_we    = wb_issue;
  assign arr_row   = wb_issue ? buf_tag[vic] : row_latch;
  assign arr_col   = wb_issue ? wb_col : col_cnt;
  assign arr_wdata = buf_data[vic][wb_col];

  rowbuf_nvarray #(
    .ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W),
    .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .CNT_W(CNT_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .req(arr_req), .we(arr_we),
    .row(arr_row), .col(arr_col), .wdata(arr_wdata),
    .busy(arr_busy), .ready(arr_ready), .rdata(arr_rdata),
    .wr_count(wr_count)
  );

  rowbuf_lru #(.NUM_BUFS(NUM_BUFS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(serve_hit),
    .touch_idx(hit_idx), .oldest_idx(lru_idx)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      vic       <= '0;
      col_cnt   <= '0;
      row_latch <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_miss) begin
          vic       <= victim;
          row_latch <= req_row;
          col_cnt   <= '0;
          state     <= victim_dirty ? ST_WB_ISSUE : ST_FILL_ISSUE;
        end
        ST_WB_ISSUE: state <= ST_WB_WAIT;
        ST_WB_WAIT: if (arr_ready)
          state <= (|buf_dirty[vic]) ? ST_WB_ISSUE : ST_FILL_ISSUE;
        ST_FILL_ISSUE: state <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (arr_ready) begin
          if (col_cnt == COL_W'(WORDS - 1)) state <= ST_IDLE;
          else begin
            col_cnt <= col_cnt + 1'b1;
            state   <= ST_FILL_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // buffer storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BUFS; i++) begin
        for (int w = 0; w < WORDS; w++) buf_data[i][w] <= '0;
        buf_tag[i]   <= '0;
        buf_dirty[i] <= '0;
        buf_valid[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NUM_BUFS; i++) begin
        if (serve_hit && hit_vec[i] && host_we) begin
          buf_data[i][req_col]  <= host_wdata;
          buf_dirty[i][req_col] <= 1'b1;
        end
        if (wb_issue && (vic == BUF_W'(i)))
          buf_dirty[i][wb_col] <= 1'b0;
        if (fill_word_done && (vic == BUF_W'(i)))
          buf_data[i][col_cnt] <= arr_rdata;
        if (fill_done && (vic == BUF_W'(i))) begin
          buf_valid[i] <= 1'b1;
          buf_tag[i]   <= row_latch;
          buf_dirty[i] <= '0;
        end
      end
    end
  end

  // host response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ready <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ready <= serve_hit;
      if (serve_hit)
        host_rdata <= host_we ? host_wdata : buf_data[hit_idx][req_col];
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R1
  AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> !host_ready); // R6
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_issue |-> buf_dirty[vic][wb_col]); // R3
  AST_CLEAN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_miss && !victim_dirty) |=> (state == ST_FILL_ISSUE)); // R4
  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (buf_dirty[vic] == '0) && buf_valid[vic]); // R8
  AST_WB_DONE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done_word |=> (state == ST_WB_ISSUE) || (state == ST_FILL_ISSUE)); // R5

endmodule

// File: tb/rowbuf_ctrl_tb.sv
`timescale 1ns/1ps
module rowbuf_ctrl_tb;
  localparam int RD   = 5;
  localparam int WR   = 15;
  localparam int CLEAN = 2 + 8 * (RD + 2);   // clean miss, 8 words per row
  localparam int PERW  = WR + 2;              // extra edges per modified word

  localparam logic [31:0] DA1 = 32'hA1A1_0001;
  localparam logic [31:0] DA2 = 32'hA2A2_0002;
  localparam logic [31:0] DA3 = 32'hA3A3_0003;
  localparam logic [31:0] DB1 = 32'hB1B1_0007;

  typedef struct packed {
    logic        we;
    logic [3:0]  row;
    logic [2:0]  col;
    logic [31:0] wdata;
    logic [31:0] rd;
    logic [15:0] lat;
    logic [15:0] wc;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VTAB [NV] = '{
    '{1'b0, 4'd0,  3'd0, 32'h0, 32'h0, 16'(CLEAN),          16'd0}, // fill empty buf
    '{1'b1, 4'd0,  3'd1, DA1,   32'h0, 16'd1,               16'd0}, // hit write
    '{1'b1, 4'd0,  3'd1, DA2,   32'h0, 16'd1,               16'd0}, // coalesce
    '{1'b1, 4'd0,  3'd5, DA3,   32'h0, 16'd1,               16'd0},
    '{1'b0, 4'd0,  3'd1, 32'h0, DA2,   16'd1,               16'd0}, // latest value
    '{1'b0, 4'd1,  3'd0, 32'h0, 32'h0, 16'(CLEAN),          16'd0}, // invalid first
    '{1'b1, 4'd1,  3'd7, DB1,   32'h0, 16'd1,               16'd0},
    '{1'b0, 4'd2,  3'd3, 32'h0, 32'h0, 16'(CLEAN),          16'd0},
    '{1'b0, 4'd3,  3'd3, 32'h0, 32'h0, 16'(CLEAN),          16'd0},
    '{1'b0, 4'd0,  3'd5, 32'h0, DA3,   16'd1,               16'd0}, // col field
    '{1'b0, 4'd4,  3'd0, 32'h0, 32'h0, 16'(CLEAN + PERW),   16'd1}, // evict row1, 1 dirty
    '{1'b0, 4'd5,  3'd0, 32'h0, 32'h0, 16'(CLEAN),          16'd1}, // evict row2 clean
    '{1'b0, 4'd1,  3'd7, 32'h0, DB1,   16'(CLEAN),          16'd1}, // persisted
    '{1'b0, 4'd6,  3'd0, 32'h0, 32'h0, 16'(CLEAN + 2*PERW), 16'd3}, // evict row0, 2 dirty
    '{1'b0, 4'd0,  3'd1, 32'h0, DA2,   16'(CLEAN),          16'd3},
    '{1'b0, 4'd7,  3'd0, 32'h0, 32'h0, 16'(CLEAN),          16'd3},
    '{1'b0, 4'd8,  3'd0, 32'h0, 32'h0, 16'(CLEAN),          16'd3}, // refetched row1 clean
    '{1'b0, 4'd9,  3'd0, 32'h0, 32'h0, 16'(CLEAN),          16'd3},
    '{1'b0, 4'd10, 3'd0, 32'h0, 32'h0, 16'(CLEAN),          16'd3}  // refetched row0 clean
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic [15:0] wr_count;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  rowbuf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .wr_count(wr_count)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [3:0] row, input logic [2:0] col,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_req   = 1'b1;
    host_we    = we;
    host_addr  = {row, col};
    host_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!host_ready && lat < 2000);
    rd = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] rd;
    int lat;
    do_reset();
    @(negedge clk);
    check("R9 ready after reset", 32'(host_ready), 32'd0);
    check("R9 wr_count after reset", 32'(wr_count), 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      do_op(VTAB[v].we, VTAB[v].row, VTAB[v].col, VTAB[v].wdata, rd, lat);
      check($sformatf("R5/R6/R1 latency vec %0d", v), 32'(lat), 32'(VTAB[v].lat));
      check($sformatf("R2/R3/R4/R8 wr_count vec %0d", v), 32'(wr_count), 32'(VTAB[v].wc));
      if (!VTAB[v].we)
        check($sformatf("R1/R3/R10 rdata vec %0d", v), rd, VTAB[v].rd);
    end

    // full row of modified words: R2, then eviction of all 8 (R3, R5)
    for (int c = 0; c < 8; c++) begin
      do_op(1'b1, 4'd7, 3'(c), 32'h7000_0000 + 32'(c), rd, lat);
      check("R1 full-row write latency", 32'(lat), 32'd1);
    end
    check("R2 no writes while coalescing", 32'(wr_count), 32'd3);
    for (int r = 11; r <= 13; r++) begin
      do_op(1'b0, 4'(r), 3'd0, 32'h0, rd, lat);
      check("R7 clean LRU evictions latency", 32'(lat), 32'(CLEAN));
    end
    do_op(1'b0, 4'd14, 3'd0, 32'h0, rd, lat);
    check("R5 full-row writeback latency", 32'(lat), 32'(CLEAN + 8 * PERW));
    check("R3 full-row writeback count", 32'(wr_count), 32'd11);
    for (int c = 0; c < 8; c++) begin
      do_op(1'b0, 4'd7, 3'(c), 32'h0, rd, lat);
      check("R3 full-row read back", rd, 32'h7000_0000 + 32'(c));
      check("R5 read back latency", 32'(lat), (c == 0) ? 32'(CLEAN) : 32'd1);
    end

    // second reset: array cleared, counter cleared
    do_reset();
    @(negedge clk);
    check("R9 wr_count after second reset", 32'(wr_count), 32'd0);
    check("R9 ready after second reset", 32'(host_ready), 32'd0);
    do_op(1'b0, 4'd7, 3'd3, 32'h0, rd, lat);
    check("R9 array cleared", rd, 32'd0);
    check("R7 empty buffer after reset", 32'(lat), 32'(CLEAN));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule